// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps wall-clock time and a calendar date in packed BCD. It advances one second for every `TICKS_PER_SEC` pulses of a tick enable, normally a 32768 Hz reference brought into the system clock domain. Seconds carry into minutes, minutes into hours, hours into the day of month, and so on through the month and a two-digit year that covers 2000 to 2099. A day-of-week counter moves with the date. Month lengths and leap years are handled in hardware.

Software reaches every field through a byte-wide register port. Writes take effect on the next clock edge and reads are combinational. A control register starts and stops the clock and selects a 12-hour display. A status register reports a busy window, the run state, sticky event flags, an alarm flag and a power-up flag. An enable register gates those flags onto a single interrupt line. Software is expected to wait for BUSY to fall and then do its accesses inside the quiet part of the second.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, 00 hours, day 01, month 01, year 00 and weekday 06. The clock is stopped, control (0x40) reads 0x00, status (0x44) reads 0x80 (power-up flag in bit 7 only) and interrupt enable (0x48) reads 0x00.
- R2: Control bit 0 is the run bit. While it is 0, tick pulses are ignored and every time field holds its value. Status bit 1 mirrors it.
- R3: While running, seconds advance exactly once per `TICKS_PER_SEC` tick pulses. A write to seconds (0x00) restarts the prescaler, so the next advance comes a full `TICKS_PER_SEC` ticks later.
- R4: In 24-hour mode, seconds (0x00) and minutes (0x04) wrap from 59 to 00 and hours (0x08) from 23 to 00. Each wrap carries into the next field, in BCD.
- R5: The day of month (0x0C) wraps to 01 after 28 or 29 in February (29 when the year is a multiple of 4), after 30 in months 04, 06, 09 and 11, and after 31 in the other months. Month (0x10) wraps 12 to 01 and year (0x14) wraps 99 to 00. Weekday (0x18) counts 0 to 6, wraps to 0, and advances whenever the day of month advances.
- R6: With control bit 3 set (12-hour mode), the hours register holds BCD 01 to 12 in bits 4:0 with PM in bit 5. The hour goes 11 to 12 and toggles PM, and goes 12 to 01 without touching PM. Going from 11 PM to 12 AM advances the day.
- R7: Writes store only the valid bits of each field: 7 for seconds and minutes, 6 for hours and day, 5 for month, 8 for year and 3 for weekday. A write in the same cycle as a seconds update replaces that field's updated value while the other fields still advance. A write to seconds in that cycle cancels the update.
- R8: Status bit 0 (BUSY) is 1 exactly while running during the last tick period before a seconds update, and it falls with the update.
- R9: Sticky event flags are set on updates. Bit 2 is set on every seconds update, bit 3 when the minutes change, bit 4 when the hours change and bit 5 when the day changes.
- R10: Status bits 7:2 clear when a 1 is written to them. Writing 0 has no effect, and bits 1:0 are read-only. A pulse on `alarm_in` sets bit 6. A set in the same cycle as a clear of the same bit leaves the bit set.
- R11: Interrupt-enable bit n (n = 2 to 7) enables status bit n onto `irq`. Writing 0 to 0x48 drops `irq` on the next cycle while the clock keeps running.
- R12: Addresses outside the register map read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick | input | 1 | One-cycle pulse per reference-clock period |
| alarm_in | input | 1 | Sets the alarm status flag |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | OR of enabled status flags |

## Verification
The collision of interest is a software write landing in the same cycle as a seconds update. The bench steers its behavioural model until the prescaler sits on its last tick, where the design should show BUSY. It then drives the write with a tick pulse in that one cycle. A write to minutes must keep its written value while seconds still wrap, and a write to seconds must cancel the update, raise no one-second flag and push the next advance a full second out. A second collision is a flag being set and cleared together, provoked by pulsing `alarm_in` during a write-one-to-clear of the same bit, and judged by the bit staying set.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_in,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [7:0] A_SEC = 8'h00, A_MIN = 8'h04, A_HR = 8'h08, A_DAY = 8'h0C,
                         A_MON = 8'h10, A_YR = 8'h14, A_WK = 8'h18,
                         A_CTL = 8'h40, A_STA = 8'h44, A_IEN = 8'h48;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  logic [PW-1:0] pre;
  logic [7:0] sec, min, hr, day, mon, yr;
  logic [2:0] wk;
  logic       run, mode12;
  logic [7:2] ev, ien;
  logic [7:0] dim, hr_next, h_inc;

  wire sec_wr = we && addr == A_SEC;
  wire busy   = run && pre == LAST;
  wire upd    = busy && tick && !sec_wr;

  wire leap    = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                       : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);
  wire pm      = hr[5];
  wire hr_wrap = mode12 ? (pm && hr[4:0] == 5'h11) : (hr == 8'h23);
  wire c_sec   = sec == 8'h59;
  wire c_min   = c_sec && min == 8'h59;
  wire c_hr    = c_min && hr_wrap;
  wire c_day   = c_hr && day == dim;
  wire c_mon   = c_day && mon == 8'h12;

  assign h_inc = bcd_inc({3'b000, hr[4:0]});

  always_comb begin
    case (mon)
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
    if (!mode12)                hr_next = hr_wrap ? 8'h00 : bcd_inc(hr);
    else if (hr[4:0] == 5'h12)  hr_next = {2'b00, pm, 5'h01};
    else if (hr[4:0] == 5'h11)  hr_next = {2'b00, ~pm, 5'h12};
    else                        hr_next = {2'b00, pm, h_inc[4:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre <= '0;
    else if (sec_wr)             pre <= '0;
    else if (run && tick)        pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= 8'h00; min <= 8'h00; hr <= 8'h00; day <= 8'h01;
      mon <= 8'h01; yr <= 8'h00; wk <= 3'd6;
      run <= 1'b0; mode12 <= 1'b0; ien <= '0;
    end else begin
      if (upd) begin
        sec <= c_sec ? 8'h00 : bcd_inc(sec);
        if (c_sec) min <= c_min ? 8'h00 : bcd_inc(min);
        if (c_min) hr <= hr_next;
        if (c_hr) begin
          day <= (day == dim) ? 8'h01 : bcd_inc(day);
          wk  <= (wk == 3'd6) ? 3'd0 : wk + 3'd1;
        end
        if (c_day) mon <= c_mon ? 8'h01 : bcd_inc(mon);
        if (c_mon) yr  <= (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
      end
      if (we) begin
        case (addr)
          A_SEC: sec <= {1'b0, wdata[6:0]};
          A_MIN: min <= {1'b0, wdata[6:0]};
          A_HR:  hr  <= {2'b00, wdata[5:0]};
          A_DAY: day <= {2'b00, wdata[5:0]};
          A_MON: mon <= {3'b000, wdata[4:0]};
          A_YR:  yr  <= wdata;
          A_WK:  wk  <= wdata[2:0];
          A_CTL: begin run <= wdata[0]; mode12 <= wdata[3]; end
          A_IEN: ien <= wdata[7:2];
          default: ;
        endcase
      end
    end
  end

  wire [7:2] ev_clr = (we && addr == A_STA) ? wdata[7:2] : 6'd0;
  wire [7:2] ev_set = {1'b0, alarm_in, upd && c_hr, upd && c_min, upd && c_sec, upd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= 6'b100000;
    else        ev <= (ev & ~ev_clr) | ev_set;
  end

  assign irq = |(ev & ien);

  always_comb begin
    case (addr)
      A_SEC:   rdata = sec;
      A_MIN:   rdata = min;
      A_HR:    rdata = hr;
      A_DAY:   rdata = day;
      A_MON:   rdata = mon;
      A_YR:    rdata = yr;
      A_WK:    rdata = {5'b00000, wk};
      A_CTL:   rdata = {4'b0000, mode12, 2'b00, run};
      A_STA:   rdata = {ev, run, busy};
      A_IEN:   rdata = {ien, 2'b00};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
  parameter int PW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          we,
  input logic [7:0]    addr,
  input logic [7:0]    wdata,
  input logic          run,
  input logic          busy,
  input logic [PW-1:0] pre,
  input logic [7:0]    sec,
  input logic [7:0]    day,
  input logic [7:2]    ev,
  input logic          irq
);
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we) |=> ($stable(sec) && $stable(day))); // R2
  AST_SEC_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h00) |=> (pre == '0)); // R3
  AST_SEC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !we) |=> (sec != $past(sec))); // R3
  AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !we) |=> !busy); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 8'h44) |=> ((ev & $past(ev)) == $past(ev))); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h48 && wdata == 8'h00) |=> !irq); // R11
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr), .wdata(wdata),
  .run(run), .busy(busy), .pre(pre), .sec(sec), .day(day), .ev(ev), .irq(irq)
);

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, alarm_in = 1'b0, we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  wire  [7:0] rdata;
  wire        irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_in(alarm_in), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit done = 0;

  logic [7:0] m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wk, m_st, m_ien;
  bit m_run, m_12;
  int m_pre;
  logic [7:0] rot [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h40, 8'h44, 8'h48};

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int i);
    return {4'(i / 10), 4'(i % 10)};
  endfunction
  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_sec;  8'h04: return m_min;  8'h08: return m_hr;
      8'h0C: return m_day;  8'h10: return m_mon;  8'h14: return m_yr;
      8'h18: return m_wk;
      8'h40: return {4'b0, m_12, 2'b0, m_run};
      8'h44: return {m_st[7:2], m_run, m_run && m_pre == TPS - 1};
      8'h48: return m_ien;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    bit secwr = we && addr == 8'h00;
    bit up = m_run && tick && m_pre == TPS - 1 && !secwr;
    bit cs = 0, cm = 0, ch = 0, pm;
    int s, mi, h, d, mo, y;
    logic [7:0] n_sec = m_sec, n_min = m_min, n_hr = m_hr, n_day = m_day;
    logic [7:0] n_mon = m_mon, n_yr = m_yr, n_wk = m_wk;
    if (secwr) m_pre = 0;
    else if (m_run && tick) m_pre = (m_pre == TPS - 1) ? 0 : m_pre + 1;
    if (up) begin
      s = b2i(m_sec); cs = (s == 59); n_sec = i2b(cs ? 0 : s + 1);
      if (cs) begin mi = b2i(m_min); cm = (mi == 59); n_min = i2b(cm ? 0 : mi + 1); end
      if (cm) begin
        if (!m_12) begin h = b2i(m_hr); ch = (h == 23); n_hr = i2b(ch ? 0 : h + 1); end
        else begin
          h = b2i(m_hr & 8'h1F); pm = m_hr[5];
          if (h == 12) h = 1;
          else if (h == 11) begin h = 12; ch = pm; pm = !pm; end
          else h = h + 1;
          n_hr = i2b(h) | (pm ? 8'h20 : 8'h00);
        end
      end
      if (ch) begin
        d = b2i(m_day); mo = b2i(m_mon); y = b2i(m_yr);
        if (d == mdays(mo, y)) begin
          n_day = 8'h01;
          if (mo == 12) begin n_mon = 8'h01; n_yr = i2b(y == 99 ? 0 : y + 1); end
          else n_mon = i2b(mo + 1);
        end else n_day = i2b(d + 1);
        n_wk = (m_wk == 8'd6) ? 8'd0 : m_wk + 8'd1;
      end
    end
    if (we && addr == 8'h44) m_st = m_st & ~(wdata & 8'hFC);
    m_st = m_st | {1'b0, alarm_in, ch, cm, cs, up, 2'b00};
    if (we) case (addr)
      8'h00: n_sec = wdata & 8'h7F;
      8'h04: n_min = wdata & 8'h7F;
      8'h08: n_hr  = wdata & 8'h3F;
      8'h0C: n_day = wdata & 8'h3F;
      8'h10: n_mon = wdata & 8'h1F;
      8'h14: n_yr  = wdata;
      8'h18: n_wk  = wdata & 8'h07;
      8'h40: begin m_run = wdata[0]; m_12 = wdata[3]; end
      8'h48: m_ien = wdata & 8'hFC;
      default: ;
    endcase
    m_sec = n_sec; m_min = n_min; m_hr = n_hr; m_day = n_day;
    m_mon = n_mon; m_yr = n_yr; m_wk = n_wk;
  endtask

  task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", r, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({req, " rdata"}, rdata, m_read(addr));
    chk({req, " irq"}, {7'b0, irq}, {7'b0, |(m_st & m_ien & 8'hFC)});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit t = 0);
    we = 1; addr = a; wdata = d; tick = t;
    cyc();
    we = 0; tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; addr = rot[i % 10]; cyc(); end
    tick = 0;
  endtask

  task automatic rd(input string r, input logic [7:0] a, input logic [7:0] exp);
    addr = a; tick = 0; cyc();
    chk(r, rdata, exp);
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, mi, s);
    wr(8'h40, m_12 ? 8'h08 : 8'h00);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d); wr(8'h18, w);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic run_secs(input int n);
    wr(8'h40, m_12 ? 8'h09 : 8'h01);
    idle(n * TPS);
    wr(8'h40, m_12 ? 8'h08 : 8'h00);
  endtask

  task automatic wait_busy();
    addr = 8'h44;
    while (m_pre != TPS - 1) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 8'h01; m_mon = 8'h01; m_yr = 0;
    m_wk = 8'h06; m_st = 8'h80; m_ien = 0; m_run = 0; m_12 = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values against literal constants
    req = "R1";
    rd("R1 sec", 8'h00, 8'h00); rd("R1 day", 8'h0C, 8'h01); rd("R1 mon", 8'h10, 8'h01);
    rd("R1 year", 8'h14, 8'h00); rd("R1 wday", 8'h18, 8'h06);
    rd("R1 status", 8'h44, 8'h80); rd("R1 ctrl", 8'h40, 8'h00); rd("R1 ien", 8'h48, 8'h00);
    // R2 stopped clock ignores ticks
    req = "R2";
    idle(20);
    rd("R2 sec held", 8'h00, 8'h00);
    // R3 one second per TPS ticks
    req = "R3";
    wr(8'h40, 8'h01);
    rd("R2 run bit", 8'h44, 8'h82);
    idle(3 * TPS);
    rd("R3 three seconds", 8'h00, 8'h03);
    wr(8'h40, 8'h00);
    // R4 carry chain in 24-hour mode
    req = "R4";
    set_time(8'h10, 8'h05, 8'h10, 8'h02, 8'h23, 8'h59, 8'h58);
    run_secs(2);
    rd("R4 hours wrap", 8'h08, 8'h00); rd("R4 min wrap", 8'h04, 8'h00);
    rd("R4 day carry", 8'h0C, 8'h11);
    // R5 month lengths, leap year, year wrap, weekday
    req = "R5";
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    run_secs(1);
    rd("R5 leap 29th", 8'h0C, 8'h29); rd("R5 wday", 8'h18, 8'h04);
    set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    run_secs(1);
    rd("R5 leap Mar", 8'h10, 8'h03); rd("R5 leap 1st", 8'h0C, 8'h01);
    set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    run_secs(1);
    rd("R5 nonleap Mar", 8'h10, 8'h03);
    set_time(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    run_secs(1);
    rd("R5 30-day month", 8'h10, 8'h05);
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    run_secs(1);
    rd("R5 year wrap", 8'h14, 8'h00); rd("R5 month wrap", 8'h10, 8'h01);
    rd("R5 wday wrap", 8'h18, 8'h00);
    // R6 12-hour mode
    req = "R6";
    m_12 = 1;
    set_time(8'h21, 8'h06, 8'h15, 8'h02, 8'h11, 8'h59, 8'h59);
    run_secs(1);
    rd("R6 11AM to 12PM", 8'h08, 8'h32);
    set_time(8'h21, 8'h06, 8'h15, 8'h02, 8'h12, 8'h59, 8'h59);
    run_secs(1);
    rd("R6 12 to 01", 8'h08, 8'h01);
    set_time(8'h21, 8'h06, 8'h15, 8'h02, 8'h31, 8'h59, 8'h59);
    run_secs(1);
    rd("R6 11PM to 12AM", 8'h08, 8'h12); rd("R6 day advance", 8'h0C, 8'h16);
    m_12 = 0;
    wr(8'h40, 8'h00);
    // R7 field masks and writes at an update
    req = "R7";
    wr(8'h00, 8'hFF); rd("R7 sec mask", 8'h00, 8'h7F);
    wr(8'h08, 8'hFF); rd("R7 hour mask", 8'h08, 8'h3F);
    wr(8'h10, 8'hFF); rd("R7 month mask", 8'h10, 8'h1F);
    wr(8'h18, 8'hFF); rd("R7 wday mask", 8'h18, 8'h07);
    wr(8'h14, 8'hFF); rd("R7 year full", 8'h14, 8'hFF);
    set_time(8'h30, 8'h07, 8'h04, 8'h01, 8'h08, 8'h10, 8'h59);
    wr(8'h44, 8'hFC);
    wr(8'h40, 8'h01);
    wait_busy();
    chk("R8 busy before update", rdata & 8'h01, 8'h01);
    wr(8'h04, 8'h42, 1);
    rd("R7 write wins minutes", 8'h04, 8'h42); rd("R7 sec still wraps", 8'h00, 8'h00);
    wr(8'h44, 8'hFC);
    wait_busy();
    wr(8'h00, 8'h30, 1);
    rd("R7 sec write cancels", 8'h00, 8'h30);
    rd("R9 no 1s flag", 8'h44, 8'h02);
    idle(TPS - 1);
    rd("R3 restart holds", 8'h00, 8'h30);
    idle(1);
    rd("R3 restart advance", 8'h00, 8'h31);
    wr(8'h40, 8'h00);
    // R9 event flags, R10 write-one-to-clear
    req = "R9";
    wr(8'h44, 8'hFC);
    set_time(8'h30, 8'h07, 8'h04, 8'h01, 8'h00, 8'h59, 8'h59);
    run_secs(1);
    rd("R9 s/m/h flags", 8'h44, 8'h1C);
    req = "R10";
    wr(8'h44, 8'h04); rd("R10 clear 1s", 8'h44, 8'h18);
    wr(8'h44, 8'h00); rd("R10 zero write", 8'h44, 8'h18);
    alarm_in = 1; cyc(); alarm_in = 0;
    rd("R10 alarm set", 8'h44, 8'h58);
    alarm_in = 1; wr(8'h44, 8'h40); alarm_in = 0;
    rd("R10 set beats clear", 8'h44, 8'h58);
    // R11 interrupt enable
    req = "R11";
    wr(8'h48, 8'h40);
    chk("R11 irq on", {7'b0, irq}, 8'h01);
    wr(8'h40, 8'h01);
    wr(8'h48, 8'h00);
    chk("R11 irq off", {7'b0, irq}, 8'h00);
    idle(TPS);
    rd("R11 clock runs", 8'h00, 8'h01);
    wr(8'h40, 8'h00);
    // R12 unmapped addresses
    req = "R12";
    rd("R12 read hole", 8'h30, 8'h00);
    wr(8'h30, 8'hFF);
    rd("R12 sec untouched", 8'h00, 8'h01);
    rd("R12 ctrl untouched", 8'h40, 8'h00);
    done = 1;
    finish_up();
  end
endmodule